// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block maps a virtual address onto a physical address through a small table of segment descriptors. The top bits of the virtual address pick one descriptor and the remaining bits form an offset inside that segment. Each descriptor holds a physical base, a size in bytes and a direction flag. A segment that grows upward places its offset above the base. A segment that grows downward, such as a stack, places it below the base. Every access is bounds-checked against the segment size, and an out-of-range access or an unused selector is reported as a fault instead of an address.

Software or a controller loads the descriptors through a simple write port. A requester presents a virtual address with a request strobe and receives one registered response on the following cycle. That response carries either a good physical address or a fault. After reset the table holds a working layout of code, heap and stack, so translation works without any programming.

Top module: `seg_xlate`

## Requirements
- R1: After reset both `rsp_ok` and `rsp_fault` are low. The table then holds entry 0 (code) with base 0x4000, size 0x1000, growing up; entry 1 (heap) with base 0x5800, size 0x1000, growing up; and entry 2 (stack) with base 0x7000, size 0x0800, growing down.
- R2: `req_vaddr[13:12]` selects the entry and `req_vaddr[11:0]` is the offset. A request sampled at one clock edge produces, at the next edge, exactly one of `rsp_ok` or `rsp_fault` high. A cycle without a request leaves both low at the next edge.
- R3: For an upward entry the access is legal when offset < size, and `rsp_paddr` = base + offset (mod 2^16).
- R4: For a downward entry the signed offset is offset − 4096, with magnitude 4096 − offset. The access is legal when that magnitude ≤ size, and `rsp_paddr` = base − (4096 − offset) (mod 2^16).
- R5: Selector value 3 does not name an entry, and any request with it faults.
- R6: Whenever `rsp_fault` is high, `rsp_paddr` is zero.
- R7: `wr_en` with `wr_sel` in 0..2 replaces that entry's base, size and direction (1 = up). The change affects requests in later cycles. A request in the same cycle as the write is translated with the old contents.
- R8: A write with `wr_sel` = 3 changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load one descriptor |
| wr_sel | input | 2 | Descriptor index to load |
| wr_base | input | 16 | New physical base |
| wr_size | input | 13 | New size in bytes (up to 4096) |
| wr_grows_up | input | 1 | New direction, 1 = upward |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 14 | Virtual address |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Access faulted |
| rsp_paddr | output | 16 | Physical address, zero on fault |

## Verification
The hardest situation to reach is the exact edge of a downward segment. There, offset zero means a full 4096-byte magnitude, and a base smaller than the magnitude wraps. The stimulus sweeps every virtual address under the reset layout. It then reloads the table with a downward code segment of full size at a low base, so offset zero becomes legal and the result wraps. It also reloads a resized upward stack and sweeps every address again. Separate directed cycles cover a write colliding with a request, and a write to the unused index.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      SEG_CODE  = 2'd0,
      SEG_HEAP  = 2'd1,
      SEG_STACK = 2'd2
   } seg_kind_e;

   // Reset layout of the descriptor table, indexed by entry number
   function automatic logic [31:0] rst_base(input int idx);
      case (idx)
         0:       return 32'h0000_4000;
         1:       return 32'h0000_5800;
         2:       return 32'h0000_7000;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] rst_size(input int idx);
      case (idx)
         0:       return 32'h0000_1000;
         1:       return 32'h0000_1000;
         2:       return 32'h0000_0800;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic rst_up(input int idx);
      return (idx != int'(SEG_STACK));
   endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table #(
   parameter int NUM_SEG = 3,
   parameter int SEL_W   = 2,
   parameter int PA_W    = 16,
   parameter int SIZE_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [PA_W-1:0]   wr_base,
   input  logic [SIZE_W-1:0] wr_size,
   input  logic              wr_grows_up,
   output logic [PA_W-1:0]   base_o [NUM_SEG],
   output logic [SIZE_W-1:0] size_o [NUM_SEG],
   output logic              up_o   [NUM_SEG]
);
   import seg_xlate_pkg::*;

   for (genvar gi = 0; gi < NUM_SEG; gi++) begin : g_ent
      localparam logic [PA_W-1:0]   RB = PA_W'(rst_base(gi));
      localparam logic [SIZE_W-1:0] RS = SIZE_W'(rst_size(gi));
      localparam logic              RU = rst_up(gi);
      logic hit;
      assign hit = wr_en && (wr_sel == SEL_W'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_o[gi] <= RB;
            size_o[gi] <= RS;
            up_o[gi]   <= RU;
         end else if (hit) begin
            base_o[gi] <= wr_base;
            size_o[gi] <= wr_size;
            up_o[gi]   <= wr_grows_up;
         end
      end
   end
endmodule

// File: rtl/seg_entry_xlate.sv
module seg_entry_xlate #(
   parameter int OFF_W  = 12,
   parameter int PA_W   = 16,
   parameter int SIZE_W = 13
) (
   input  logic [PA_W-1:0]   base,
   input  logic [SIZE_W-1:0] size,
   input  logic              grows_up,
   input  logic [OFF_W-1:0]  offset,
   output logic [PA_W-1:0]   paddr,
   output logic              legal
);
   localparam logic [SIZE_W-1:0] SPAN = SIZE_W'(1) << OFF_W;

   logic [SIZE_W-1:0] off_ext;
   logic [SIZE_W-1:0] down_mag;
   logic [PA_W-1:0]   up_pa;
   logic [PA_W-1:0]   down_pa;

   assign off_ext  = {1'b0, offset};
   assign down_mag = SPAN - off_ext;
   assign up_pa    = base + PA_W'(off_ext);
   assign down_pa  = base - PA_W'(down_mag);

   always_comb begin
      if (grows_up) begin
         legal = off_ext < size;
         paddr = up_pa;
      end else begin
         legal = down_mag <= size;
         paddr = down_pa;
      end
   end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
   parameter int NUM_SEG = 3,
   parameter int VA_W    = 14,
   parameter int SEL_W   = 2,
   parameter int PA_W    = 16,
   parameter int SIZE_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [PA_W-1:0]   wr_base,
   input  logic [SIZE_W-1:0] wr_size,
   input  logic              wr_grows_up,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_vaddr,
   output logic              rsp_ok,
   output logic              rsp_fault,
   output logic [PA_W-1:0]   rsp_paddr
);
   localparam int OFF_W = VA_W - SEL_W;

   if (NUM_SEG < 1 || NUM_SEG > (1 << SEL_W)) begin : g_bad_num
      initial $error("NUM_SEG must fit the selector field");
   end
   if (SIZE_W != OFF_W + 1) begin : g_bad_size
      initial $error("SIZE_W must be offset width plus one");
   end
   if (PA_W < SIZE_W || PA_W < 15) begin : g_bad_pa
      initial $error("PA_W too narrow for sizes or reset bases");
   end

   logic [PA_W-1:0]   tb_base [NUM_SEG];
   logic [SIZE_W-1:0] tb_size [NUM_SEG];
   logic              tb_up   [NUM_SEG];

   seg_table #(
      .NUM_SEG(NUM_SEG), .SEL_W(SEL_W), .PA_W(PA_W), .SIZE_W(SIZE_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_base(wr_base),
      .wr_size(wr_size), .wr_grows_up(wr_grows_up),
      .base_o(tb_base), .size_o(tb_size), .up_o(tb_up)
   );

   logic [SEL_W-1:0] sel;
   logic [OFF_W-1:0] off;
   assign sel = req_vaddr[VA_W-1:OFF_W];
   assign off = req_vaddr[OFF_W-1:0];

   logic [PA_W-1:0] ent_pa    [NUM_SEG];
   logic            ent_legal [NUM_SEG];

   for (genvar gi = 0; gi < NUM_SEG; gi++) begin : g_x
      seg_entry_xlate #(
         .OFF_W(OFF_W), .PA_W(PA_W), .SIZE_W(SIZE_W)
      ) u_ent (
         .base(tb_base[gi]), .size(tb_size[gi]), .grows_up(tb_up[gi]),
         .offset(off), .paddr(ent_pa[gi]), .legal(ent_legal[gi])
      );
   end

   logic            pick_legal;
   logic [PA_W-1:0] pick_pa;
   always_comb begin
      pick_legal = 1'b0;
      pick_pa    = '0;
      for (int i = 0; i < NUM_SEG; i++) begin
         if (sel == SEL_W'(i)) begin
            pick_legal = ent_legal[i];
            pick_pa    = ent_pa[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_ok    <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_paddr <= '0;
      end else begin
         rsp_ok    <= req_valid && pick_legal;
         rsp_fault <= req_valid && !pick_legal;
         rsp_paddr <= (req_valid && pick_legal) ? pick_pa : '0;
      end
   end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int VA_W  = 14,
   parameter int SEL_W = 2,
   parameter int PA_W  = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [VA_W-1:0] req_vaddr,
   input logic            rsp_ok,
   input logic            rsp_fault,
   input logic [PA_W-1:0] rsp_paddr
);
   a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_ok ^ rsp_fault));

   a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_ok && !rsp_fault));

   a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_ok, rsp_fault}));

   a_r5_unused_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_vaddr[VA_W-1 -: SEL_W] == {SEL_W{1'b1}}) |=> rsp_fault);

   a_r6_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_paddr == '0));
endmodule

bind seg_xlate seg_xlate_chk #(.VA_W(VA_W), .SEL_W(SEL_W), .PA_W(PA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
   .rsp_ok(rsp_ok), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [15:0] wr_base = '0;
   logic [12:0] wr_size = '0;
   logic        wr_grows_up = 1'b0;
   logic        req_valid = 1'b0;
   logic [13:0] req_vaddr = '0;
   logic        rsp_ok, rsp_fault;
   logic [15:0] rsp_paddr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int m_base [3];
   int m_size [3];
   bit m_up   [3];

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_base(wr_base), .wr_size(wr_size), .wr_grows_up(wr_grows_up),
      .req_valid(req_valid), .req_vaddr(req_vaddr),
      .rsp_ok(rsp_ok), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
   );

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // expected: ok flag and physical address from the bench's own table model
   task automatic model(input int va, output bit ok, output int pa);
      int sel = (va >> 12) & 3;
      int off = va & 12'hFFF;
      ok = 1'b0;
      pa = 0;
      if (sel < 3) begin
         if (m_up[sel]) begin
            ok = off < m_size[sel];
            pa = (m_base[sel] + off) & 16'hFFFF;
         end else begin
            ok = (4096 - off) <= m_size[sel];
            pa = (m_base[sel] - (4096 - off)) & 16'hFFFF;
         end
      end
      if (!ok) pa = 0;
   endtask

   task automatic translate(input int va, input string req);
      bit ok;
      int pa;
      model(va, ok, pa);
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = 14'(va);
      @(negedge clk);
      req_valid = 1'b0;
      check(req, int'(rsp_ok), int'(ok), $sformatf("ok va=0x%0h", va));
      check(req, int'(rsp_fault), int'(!ok), $sformatf("fault va=0x%0h", va));
      check(req, int'(rsp_paddr), pa, $sformatf("paddr va=0x%0h", va));
   endtask

   task automatic write_ent(input int idx, input int b, input int s, input bit up);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'(idx); wr_base = 16'(b);
      wr_size = 13'(s); wr_grows_up = up;
      @(negedge clk);
      wr_en = 1'b0;
      if (idx < 3) begin
         m_base[idx] = b; m_size[idx] = s; m_up[idx] = up;
      end
   endtask

   task automatic sweep(input string req);
      for (int va = 0; va < 16384; va++) translate(va, req);
   endtask

   initial begin
      for (int i = 0; i < 3; i++) begin
         m_base[i] = (i == 0) ? 16'h4000 : (i == 1) ? 16'h5800 : 16'h7000;
         m_size[i] = (i == 2) ? 16'h0800 : 16'h1000;
         m_up[i]   = (i != 2);
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", int'(rsp_ok), 0, "ok in reset");
      check("R1", int'(rsp_fault), 0, "fault in reset");
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      // R2 idle cycles give no response
      check("R2", int'(rsp_ok), 0, "ok idle");
      check("R2", int'(rsp_fault), 0, "fault idle");

      // R1 R3 R4 R5 R6: directed edges of the reset layout
      translate(14'h0000, "R3");
      translate(14'h0FFF, "R3");
      translate(14'h1FFF, "R3");
      translate(14'h27FF, "R4");
      translate(14'h2800, "R4");
      translate(14'h2FFF, "R4");
      translate(14'h3123, "R5");
      // full sweep of the reset layout: R1 R3 R4 R5 R6
      sweep("R1");

      // R8 write to unused index changes nothing
      write_ent(3, 16'h0100, 16'h0010, 1'b1);
      translate(14'h0800, "R8");
      translate(14'h1800, "R8");
      translate(14'h2C00, "R8");
      translate(14'h3000, "R8");

      // R7 write colliding with a request uses old contents
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'd1; wr_base = 16'h0200; wr_size = 13'h0100; wr_grows_up = 1'b1;
      req_valid = 1'b1; req_vaddr = 14'h1040;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      check("R7", int'(rsp_ok), 1, "ok same-cycle write");
      check("R7", int'(rsp_paddr), 16'h5840, "paddr same-cycle write");
      m_base[1] = 16'h0200; m_size[1] = 16'h0100; m_up[1] = 1'b1;
      translate(14'h1040, "R7");
      translate(14'h1100, "R7");

      // R4 full-size downward code segment wrapping below zero; R3 up stack
      write_ent(0, 16'h0400, 16'h1000, 1'b0);
      write_ent(2, 16'hFF00, 16'h0300, 1'b1);
      translate(14'h0000, "R4");
      translate(14'h22FF, "R3");
      translate(14'h2300, "R3");
      sweep("R7");

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (150000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule